// File: doc/BRIEF.md
# Indirect Hierarchical Interrupt Controller

This block gathers 256 interrupt lines into one summary interrupt for a host that reaches it through a narrow register port, 16-bit address and 8-bit data. The lines are grouped eight to a block, eight blocks to a master and four masters in all. A status tree of root, master and block bytes lets an interrupt handler walk from the summary to the exact line in a few reads.

Per-line control is indirect. The host first writes a block number into a select register. A single configuration byte then addresses one line inside that block, through a 3-bit index field. The same select register picks which block's pending bits and synchronized live levels appear at two read addresses. Each line can be armed for a rising edge, a falling edge, both edges, a high level or a low level. A line can also be cleared, or masked and acknowledged in one write.

The serial transport in front of the register port is not part of this block. Reads are combinational from the address. Writes take effect on the clock edge where `host_wr` is high.

Top module: `irqh_ctrl`

## Requirements
- R1: After reset every line is fully masked (config bits 2 and 1 set, level mode off), nothing is pending, `irq_out` is 0, and the block select and all status bytes read 0.
- R2: The register window starts at 0x1BB. Root is at +0, master n status at +1+n (n = 0..3), block select at +5, pending status at +6, config at +7 and live status at +8. Reads of config and of any address outside +0..+8 (except config) return 0.
- R3: With config bit0 = 0 (edge mode), a line latches on a rising edge when bit2 is clear and on a falling edge when bit1 is clear. Both edges latch when both bits are clear.
- R4: With config bit0 = 1 (level mode), a line latches while high when bit2 is clear and while low when bit1 is clear. A clear while the level is still active leaves it pending again.
- R5: A config byte carries the line index within the selected block in bits 6:4 and a write strobe in bit7. A config write with bit7 = 0 changes nothing.
- R6: Config bit3 clears that line's latch and is not stored. A write with bits 3, 2 and 1 all set masks and acknowledges the line, so it reads as not pending from the next cycle.
- R7: The pending status byte, bit b, is 1 when line 8*sel+b is latched and not fully masked. A fully masked line never latches.
- R8: Master n status bit i is the OR of the pending byte of block 8n+i. Root bit n+1 is the OR of master n. Root bit 0 is always 0. `irq_out` is the OR of the root.
- R9: The block select holds 5 bits; a write of a value of 32 or more leaves it unchanged, and it reads back at +5.
- R10: The live status byte shows the selected block's lines after a two-flop synchronizer: an input change is visible after the second rising clock edge. Latching happens one edge later, against a registered copy of the synchronized level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 256 | Raw interrupt lines, line g = block*8 + bit |
| host_addr | input | 16 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq_out | output | 1 | Summary interrupt |

## Verification
A vector table runs each trigger mode against pairs of line transitions, one that should latch and one that should not. Lines are spread across every master, so a correct pending bit with a wrong master or root bit exposes a mis-indexed tree. Directed tests cover the following:
- a level clear while the line is still high, which separates re-assertion from an edge latch that stays cleared;
- a config write without its strobe;
- a block select beyond 31, and the boundary value 31;
- the exact edge at which a live level first appears;
- two lines pending in different masters at once, so the root must show two distinct bits.

// File: rtl/irqh_pkg.sv
`timescale 1ns/1ps
package irqh_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    // register offsets from the window base
    localparam int OFF_ROOT = 0;
    localparam int OFF_MSTR = 1;
    localparam int OFF_BSEL = 5;
    localparam int OFF_PEND = 6;
    localparam int OFF_CFG  = 7;
    localparam int OFF_LIVE = 8;

    // config byte fields
    localparam int CB_LVL    = 0;
    localparam int CB_MLO    = 1;
    localparam int CB_MHI    = 2;
    localparam int CB_CLR    = 3;
    localparam int CB_IDX    = 4;
    localparam int CB_STROBE = 7;

    typedef struct packed {
        logic lvl;      // 1: level mode
        logic mask_lo;  // masks falling edge / low level
        logic mask_hi;  // masks rising edge / high level
    } src_cfg_t;

    localparam src_cfg_t CFG_RESET = '{lvl: 1'b0, mask_lo: 1'b1, mask_hi: 1'b1};
endpackage

// File: rtl/irqh_src_cell.sv
`timescale 1ns/1ps
module irqh_src_cell
    import irqh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     raw_i,
    input  logic     cfg_we_i,
    input  src_cfg_t cfg_i,
    input  logic     clr_i,
    output logic     line_o,
    output logic     pend_o
);
    typedef struct packed {
        logic     sync;
        logic     line;
        logic     prev;
        src_cfg_t cfg;
        logic     latch;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic rise, fall, hit;

    always_comb begin
        st_d      = st_q;
        st_d.sync = raw_i;
        st_d.line = st_q.sync;
        st_d.prev = st_q.line;
        rise = st_q.line & ~st_q.prev;
        fall = ~st_q.line & st_q.prev;
        if (st_q.cfg.lvl)
            hit = (st_q.line & ~st_q.cfg.mask_hi) | (~st_q.line & ~st_q.cfg.mask_lo);
        else
            hit = (rise & ~st_q.cfg.mask_hi) | (fall & ~st_q.cfg.mask_lo);
        if (cfg_we_i) begin
            st_d.cfg = cfg_i;
            if (clr_i)
                st_d.latch = 1'b0;
        end
        // a detection in the same cycle wins over a clear
        if (hit)
            st_d.latch = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: 1'b0, line: 1'b0, prev: 1'b0, cfg: CFG_RESET, latch: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
    assign pend_o = st_q.latch & ~(st_q.cfg.mask_hi & st_q.cfg.mask_lo);

    // R3: an armed rising edge is latched on the next edge
    a_r3_rise_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cfg.lvl && !st_q.cfg.mask_hi && st_q.line && !st_q.prev) |=> st_q.latch);

    // R4: an armed active-high level keeps the latch set
    a_r4_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.lvl && !st_q.cfg.mask_hi && st_q.line) |=> st_q.latch);

    // R5: configuration only moves on a strobed write
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(st_q.cfg));

    // R6: mask-and-acknowledge hides the line from the next cycle
    a_r6_mask_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && clr_i && cfg_i.mask_hi && cfg_i.mask_lo) |=> !pend_o);
endmodule

// File: rtl/irqh_tree.sv
`timescale 1ns/1ps
module irqh_tree #(
    parameter int NUM_MASTERS    = 4,
    parameter int BLK_PER_MASTER = 8,
    parameter int SRC_PER_BLK    = 8,
    localparam int NUM_BLOCKS    = NUM_MASTERS * BLK_PER_MASTER,
    localparam int NUM_SRC       = NUM_BLOCKS * SRC_PER_BLK
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     pend_i,
    output logic [NUM_BLOCKS-1:0]  blk_any_o,
    output logic [NUM_MASTERS:0]   root_o,
    output logic                   irq_o
);
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        assign blk_any_o[b] = |pend_i[b*SRC_PER_BLK +: SRC_PER_BLK];
    end

    assign root_o[0] = 1'b0;
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
        assign root_o[m+1] = |blk_any_o[m*BLK_PER_MASTER +: BLK_PER_MASTER];
    end

    assign irq_o = |root_o;

    // R8: the summary agrees with the raw pending lines
    a_r8_irq_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pend_i != '0));

    // R8: root bit 0 never rises
    a_r8_root_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        !root_o[0]);
endmodule

// File: rtl/irqh_ctrl.sv
`timescale 1ns/1ps
module irqh_ctrl
    import irqh_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR      = 16'h01BB,
    parameter int          NUM_MASTERS    = 4,
    parameter int          BLK_PER_MASTER = 8,
    parameter int          SRC_PER_BLK    = 8,
    localparam int         NUM_BLOCKS     = NUM_MASTERS * BLK_PER_MASTER,
    localparam int         NUM_SRC        = NUM_BLOCKS * SRC_PER_BLK,
    localparam int         BSEL_W         = $clog2(NUM_BLOCKS),
    localparam int         IDX_W          = $clog2(SRC_PER_BLK),
    localparam int         SRC_W          = BSEL_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [15:0]        host_addr,
    input  logic               host_wr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    output logic               irq_out
);
    localparam logic [15:0] A_ROOT = BASE_ADDR + 16'(OFF_ROOT);
    localparam logic [15:0] A_MSTR = BASE_ADDR + 16'(OFF_MSTR);
    localparam logic [15:0] A_BSEL = BASE_ADDR + 16'(OFF_BSEL);
    localparam logic [15:0] A_PEND = BASE_ADDR + 16'(OFF_PEND);
    localparam logic [15:0] A_LIVE = BASE_ADDR + 16'(OFF_LIVE);
    localparam logic [15:0] A_CFG  = BASE_ADDR + 16'(OFF_CFG);

    typedef struct packed {
        logic [BSEL_W-1:0] blksel;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic                  bsel_wr, cfg_wr, clr_bit;
    logic [SRC_W-1:0]      cfg_target;
    src_cfg_t              cfg_word;
    logic [NUM_SRC-1:0]    line_vec, pend_vec;
    logic [NUM_BLOCKS-1:0] blk_any;
    logic [NUM_MASTERS:0]  root;

    always_comb begin
        st_d    = st_q;
        bsel_wr = host_wr && (host_addr == A_BSEL);
        if (bsel_wr && (int'(host_wdata) < NUM_BLOCKS))
            st_d.blksel = host_wdata[BSEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_wr     = host_wr && (host_addr == A_CFG) && host_wdata[CB_STROBE];
    assign cfg_target = {st_q.blksel, host_wdata[CB_IDX +: IDX_W]};
    assign clr_bit    = host_wdata[CB_CLR];
    assign cfg_word   = '{lvl: host_wdata[CB_LVL], mask_lo: host_wdata[CB_MLO],
                          mask_hi: host_wdata[CB_MHI]};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irqh_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (src_in[g]),
            .cfg_we_i (cfg_wr && (cfg_target == SRC_W'(g))),
            .cfg_i    (cfg_word),
            .clr_i    (clr_bit),
            .line_o   (line_vec[g]),
            .pend_o   (pend_vec[g])
        );
    end

    irqh_tree #(
        .NUM_MASTERS    (NUM_MASTERS),
        .BLK_PER_MASTER (BLK_PER_MASTER),
        .SRC_PER_BLK    (SRC_PER_BLK)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_vec),
        .blk_any_o (blk_any),
        .root_o    (root),
        .irq_o     (irq_out)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == A_ROOT)
            host_rdata = 8'(root);
        if (host_addr == A_BSEL)
            host_rdata = 8'(st_q.blksel);
        if (host_addr == A_PEND)
            host_rdata = 8'(pend_vec[st_q.blksel*SRC_PER_BLK +: SRC_PER_BLK]);
        if (host_addr == A_LIVE)
            host_rdata = 8'(line_vec[st_q.blksel*SRC_PER_BLK +: SRC_PER_BLK]);
        for (int m = 0; m < NUM_MASTERS; m++) begin
            if (host_addr == A_MSTR + 16'(m))
                host_rdata = 8'(blk_any[m*BLK_PER_MASTER +: BLK_PER_MASTER]);
        end
    end

    // R9: an out-of-range select write leaves the selection alone
    a_r9_bsel_oob: assert property (@(posedge clk) disable iff (!rst_n)
        (bsel_wr && (int'(host_wdata) >= NUM_BLOCKS)) |=> $stable(st_q.blksel));

    // R2: the configuration address never reads back data
    a_r2_cfg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == A_CFG) |-> (host_rdata == 8'h00));
endmodule

// File: tb/irqh_ctrl_tb.sv
`timescale 1ns/1ps
module irqh_ctrl_tb;
    localparam logic [15:0] BASE = 16'h01BB;
    localparam logic [15:0] A_ROOT = BASE + 16'd0;
    localparam logic [15:0] A_BSEL = BASE + 16'd5;
    localparam logic [15:0] A_PEND = BASE + 16'd6;
    localparam logic [15:0] A_CFG  = BASE + 16'd7;
    localparam logic [15:0] A_LIVE = BASE + 16'd8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] src = '0;
    logic [15:0]  host_addr = '0;
    logic         host_wr = 1'b0;
    logic [7:0]   host_wdata = '0;
    logic [7:0]   host_rdata;
    logic         irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irqh_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_in     (src),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq_out    (irq_out)
    );

    // vector: {line[7:0], lvl, mask_lo, mask_hi, start level, end level, expect pending}
    localparam logic [13:0] VEC [11] = '{
        {8'd5,   3'b010, 1'b0, 1'b1, 1'b1},  // R3 rising armed, rises
        {8'd5,   3'b010, 1'b1, 1'b0, 1'b0},  // R3 rising armed, falls
        {8'd77,  3'b001, 1'b1, 1'b0, 1'b1},  // R3 falling armed, falls
        {8'd77,  3'b001, 1'b0, 1'b1, 1'b0},  // R3 falling armed, rises
        {8'd130, 3'b000, 1'b0, 1'b1, 1'b1},  // R3 both edges, rises
        {8'd130, 3'b000, 1'b1, 1'b0, 1'b1},  // R3 both edges, falls
        {8'd200, 3'b110, 1'b0, 1'b1, 1'b1},  // R4 active high, goes high
        {8'd200, 3'b110, 1'b0, 1'b0, 1'b0},  // R4 active high, stays low
        {8'd255, 3'b101, 1'b1, 1'b0, 1'b1},  // R4 active low, goes low
        {8'd255, 3'b101, 1'b1, 1'b1, 1'b0},  // R4 active low, stays high
        {8'd63,  3'b011, 1'b0, 1'b1, 1'b0}   // R7 fully masked edge line
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic logic [7:0] cfg_byte(input int idx, input logic [2:0] mode, input logic clr);
        return 8'h80 | 8'((idx % 8) << 4) | (clr ? 8'h08 : 8'h00)
             | {5'b0, mode[0], mode[1], mode[2]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        rd(A_ROOT, d); chk("R1 root", d, 8'h00);
        for (int m = 0; m < 4; m++) begin
            rd(BASE + 16'(1 + m), d); chk("R1 master", d, 8'h00);
        end
        rd(A_BSEL, d); chk("R1 bsel", d, 8'h00);
        rd(A_PEND, d); chk("R1 pend", d, 8'h00);
        chk("R1 irq", {7'b0, irq_out}, 8'h00);
        // R1: lines are masked, a rising edge after reset does nothing
        src[2] = 1'b1; wait_clk(5);
        rd(A_PEND, d); chk("R1 masked at reset", d, 8'h00);
        src[2] = 1'b0; wait_clk(4);

        // table walk
        foreach (VEC[v]) begin
            int idx = int'(VEC[v][13:6]);
            logic [2:0] mode = VEC[v][5:3];
            logic st = VEC[v][2], en = VEC[v][1], ex = VEC[v][0];
            src[idx] = st; wait_clk(4);
            wr(A_BSEL, 8'(idx / 8));
            wr(A_CFG, cfg_byte(idx, mode, 1'b1));
            wait_clk(2);
            src[idx] = en; wait_clk(5);
            rd(A_PEND, d);
            chk("R3/R4/R7 table pend", d, ex ? 8'(1 << (idx % 8)) : 8'h00);
            rd(BASE + 16'(1 + idx / 64), d);
            chk("R8 table master", d, ex ? 8'(1 << ((idx / 8) % 8)) : 8'h00);
            rd(A_ROOT, d);
            chk("R8 table root", d, ex ? 8'(1 << (idx / 64 + 1)) : 8'h00);
            chk("R8 table irq", {7'b0, irq_out}, {7'b0, ex});
            wr(A_CFG, cfg_byte(idx, 3'b011, 1'b1));   // R6 mask-and-ack
            src[idx] = 1'b0; wait_clk(4);
            rd(A_PEND, d); chk("R6 table ack", d, 8'h00);
        end

        // R4 level re-asserts after clear; R6 mask-and-ack removes it
        src[17] = 1'b1; wait_clk(4);
        wr(A_BSEL, 8'd2);
        wr(A_CFG, cfg_byte(17, 3'b110, 1'b1));
        wait_clk(4);
        rd(A_PEND, d); chk("R4 level latched", d, 8'h02);
        wr(A_CFG, cfg_byte(17, 3'b110, 1'b1));
        wait_clk(4);
        rd(A_PEND, d); chk("R4 level re-asserts", d, 8'h02);
        wr(A_CFG, cfg_byte(17, 3'b011, 1'b1));
        wait_clk(2);
        rd(A_PEND, d); chk("R6 mask ack pend", d, 8'h00);
        chk("R6 mask ack irq", {7'b0, irq_out}, 8'h00);
        src[17] = 1'b0; wait_clk(4);

        // R6 edge latch cleared stays cleared; R2 undefined reads
        wr(A_CFG, cfg_byte(17, 3'b010, 1'b1));
        src[17] = 1'b1; wait_clk(5);
        rd(A_PEND, d); chk("R3 edge latched", d, 8'h02);
        rd(16'h01BA, d); chk("R2 below window", d, 8'h00);
        rd(16'h01C4, d); chk("R2 above window", d, 8'h00);
        rd(A_CFG, d);    chk("R2 config reads 0", d, 8'h00);
        wr(A_CFG, cfg_byte(17, 3'b010, 1'b1));
        wait_clk(3);
        rd(A_PEND, d); chk("R6 edge clear", d, 8'h00);
        wr(A_CFG, cfg_byte(17, 3'b011, 1'b1));
        src[17] = 1'b0; wait_clk(4);

        // R5 write without strobe is ignored
        wr(A_CFG, cfg_byte(17, 3'b010, 1'b0) & 8'h7F);
        src[17] = 1'b1; wait_clk(5);
        rd(A_PEND, d); chk("R5 no strobe", d, 8'h00);
        chk("R5 no strobe irq", {7'b0, irq_out}, 8'h00);
        src[17] = 1'b0; wait_clk(4);

        // R9 block select range
        wr(A_BSEL, 8'd3);  rd(A_BSEL, d); chk("R9 bsel 3", d, 8'd3);
        wr(A_BSEL, 8'd40); rd(A_BSEL, d); chk("R9 bsel 40 ignored", d, 8'd3);
        wr(A_BSEL, 8'd32); rd(A_BSEL, d); chk("R9 bsel 32 ignored", d, 8'd3);
        wr(A_BSEL, 8'd31); rd(A_BSEL, d); chk("R9 bsel 31", d, 8'd31);

        // R10 live status latency
        wr(A_BSEL, 8'd9);
        @(negedge clk);
        src[72 +: 8] = 8'hA5;
        host_addr = A_LIVE;
        @(posedge clk); #1 chk("R10 live after 1 edge", host_rdata, 8'h00);
        @(posedge clk); #1 chk("R10 live after 2 edges", host_rdata, 8'hA5);
        rd(A_PEND, d); chk("R7 masked lines not pending", d, 8'h00);
        src[72 +: 8] = 8'h00; wait_clk(4);

        // R8 two masters pending together
        wr(A_BSEL, 8'd0);  wr(A_CFG, cfg_byte(3, 3'b010, 1'b1));
        wr(A_BSEL, 8'd31); wr(A_CFG, cfg_byte(250, 3'b010, 1'b1));
        src[3] = 1'b1; src[250] = 1'b1; wait_clk(5);
        rd(A_ROOT, d); chk("R8 two masters root", d, 8'h12);
        rd(BASE + 16'd4, d); chk("R8 master 3", d, 8'h80);
        rd(BASE + 16'd1, d); chk("R8 master 0", d, 8'h01);
        rd(A_PEND, d); chk("R8 block 31 pend", d, 8'h04);
        wr(A_CFG, cfg_byte(250, 3'b011, 1'b1));
        wait_clk(2);
        rd(A_ROOT, d); chk("R8 one master left", d, 8'h02);
        chk("R8 irq still set", {7'b0, irq_out}, 8'h01);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule